// File: doc/BRIEF.md
# Sideband Message Bus Bridge

This block turns host writes to two 32-bit configuration registers into single transactions on an internal message bus. The message bus reaches the register files of on-chip units. A command register holds the operation, the target port, the target register offset and the byte enables. A data register holds the write data before a command is issued and the returned data after a read completes.

Software issues a write by loading the data register first and then writing the command. Writing the command launches the request, and the data already staged travels with it. Software issues a read by writing a read command, waiting until busy drops, and then reading the data register. Unknown operation codes launch nothing and set a sticky error flag. While a request is outstanding, host writes to either register are dropped.

Top module: `msgbus_bridge`

## Requirements
- R1: After reset, busy, error and the bus request are low, and both the command and data registers read back as zero.
- R2: A host write to offset 0xD4 while idle stores the word in the data register, which reads back at 0xD4. Such a write starts no bus request.
- R3: A host write to offset 0xD0 while idle with bits [31:24] = 0xE0 raises the request on the next cycle. The request has write = 1, port = bits [23:16], register offset = bits [15:8], byte enables = bits [7:4] and write data = the data register contents.
- R4: A command with bits [31:24] = 0xD0 raises a request with write = 0. When the target acknowledges, the data register takes the returned word.
- R5: The request and all its fields stay constant until the acknowledge cycle. busy equals the request, and it drops on the cycle after the acknowledge.
- R6: Host writes to either offset while busy change neither register and start no new request.
- R7: Any other opcode in bits [31:24] starts no request and sets the error flag. The error flag stays set until reset, and later valid commands still run.
- R8: Byte enables pass through unchanged: byte-enable bit 4 of the command governs data bits [7:0], and so on up to bit 7 for data bits [31:24]. Only the enabled lanes of the target register change.
- R9: A host read at 0xD0 returns the last command word accepted while idle. A host read at any offset other than 0xD0 or 0xD4 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| busy | output | 1 | Transaction outstanding |
| err | output | 1 | Sticky bad-opcode flag |
| mb_req | output | 1 | Message bus request |
| mb_write | output | 1 | 1 = write, 0 = read |
| mb_port | output | 8 | Target port |
| mb_offset | output | 8 | Target register offset |
| mb_be | output | 4 | Byte enables |
| mb_wdata | output | 32 | Write data |
| mb_ack | input | 1 | Target acknowledge, one cycle |
| mb_rdata | input | 32 | Read data, valid with mb_ack |

## Verification
The bench uses random mixes of full and partial byte-enable writes and reads over random offsets, against a target whose acknowledge latency varies. This separates correct lane masking and correct data return from stale or misrouted data. Directed cases cover three situations. Staged data must not reach the target before a command is written. Writes during busy must be dropped, which shows whether commands are gated. Bad opcodes must set the error flag without causing a transaction.

// File: rtl/msgbus_bridge.sv
module msgbus_bridge #(
  parameter logic [7:0] CTRL_OFS = 8'hD0,
  parameter logic [7:0] DATA_OFS = 8'hD4,
  parameter logic [7:0] OP_RD    = 8'hD0,
  parameter logic [7:0] OP_WR    = 8'hE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        busy,
  output logic        err,
  output logic        mb_req,
  output logic        mb_write,
  output logic [7:0]  mb_port,
  output logic [7:0]  mb_offset,
  output logic [3:0]  mb_be,
  output logic [31:0] mb_wdata,
  input  logic        mb_ack,
  input  logic [31:0] mb_rdata
);
  logic [31:0] cmd_q, data_q;
  logic        req_q, err_q;

  wire       ctrl_hit = host_wr && !req_q && host_addr == CTRL_OFS;
  wire       data_hit = host_wr && !req_q && host_addr == DATA_OFS;
  wire [7:0] new_op   = host_wdata[31:24];
  wire       op_ok    = new_op == OP_RD || new_op == OP_WR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      req_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ctrl_hit) begin
        cmd_q <= host_wdata;
        if (op_ok) req_q <= 1'b1;
        else       err_q <= 1'b1;
      end
      if (data_hit) data_q <= host_wdata;
      if (req_q && mb_ack) begin
        req_q <= 1'b0;
        if (!mb_write) data_q <= mb_rdata;
      end
    end
  end

  assign busy      = req_q;
  assign err       = err_q;
  assign mb_req    = req_q;
  assign mb_write  = cmd_q[31:24] == OP_WR;
  assign mb_port   = cmd_q[23:16];
  assign mb_offset = cmd_q[15:8];
  assign mb_be     = cmd_q[7:4];
  assign mb_wdata  = data_q;
  assign host_rdata = host_addr == CTRL_OFS ? cmd_q :
                      host_addr == DATA_OFS ? data_q : 32'h0;

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && !mb_ack |=> mb_req && $stable(mb_port) && $stable(mb_offset)
                          && $stable(mb_be) && $stable(mb_wdata) && $stable(mb_write));
  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && mb_ack |=> !mb_req);
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mb_ack |=> $stable(host_rdata) || host_addr != $past(host_addr));
  assert_bad_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !busy && host_addr == CTRL_OFS && !op_ok |=> err && !mb_req);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !busy && host_addr == CTRL_OFS && new_op == OP_WR |=> mb_req && mb_write);
endmodule

// File: tb/msgbus_bridge_bench.sv
module msgbus_bridge_bench;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0;
  logic [7:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic busy, err, mb_req, mb_write, mb_ack = 0;
  logic [7:0] mb_port, mb_offset;
  logic [3:0] mb_be;
  logic [31:0] mb_wdata, mb_rdata = 0;

  msgbus_bridge u_msgbus_bridge (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] tgt [256];
  logic [31:0] exp_reg [256];
  int wait_cnt = 0;
  int max_lat = 3;

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] cmd(logic [7:0] op, logic [7:0] ofs, logic [3:0] be);
    return {op, 8'h03, ofs, be, 4'h0};
  endfunction

  always @(posedge clk) begin
    mb_ack <= 1'b0;
    if (mb_req && !mb_ack) begin
      if (wait_cnt == 0) begin
        mb_ack <= 1'b1;
        if (mb_write) tgt[mb_offset] <= merge(tgt[mb_offset], mb_wdata, mb_be);
        else mb_rdata <= tgt[mb_offset];
        wait_cnt <= $urandom % (max_lat + 1);
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_up();
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hread(logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  logic [31:0] rd, c0;

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) begin
      tgt[i] = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
      exp_reg[i] = tgt[i];
    end
    repeat (3) @(negedge clk);
    check(!busy && !err && !mb_req, "R1 status", {busy, err, mb_req}, 0);
    hread(8'hD0, rd); check(rd == 0, "R1 ctrl", rd, 0);
    hread(8'hD4, rd); check(rd == 0, "R1 data", rd, 0);
    rst_n = 1;

    hwrite(8'hD4, 32'hCAFE_F00D);
    hread(8'hD4, rd); check(rd == 32'hCAFE_F00D, "R2 stage", rd, 32'hCAFE_F00D);
    repeat (4) begin check(!mb_req, "R2 no send", mb_req, 0); @(negedge clk); end
    hwrite(8'hD0, cmd(8'hD0, 8'h10, 4'hF)); wait_idle();
    hread(8'hD4, rd); check(rd == exp_reg[16], "R2 target untouched", rd, exp_reg[16]);

    hwrite(8'hD4, 32'h1234_5678);
    @(negedge clk); host_wr = 1; host_addr = 8'hD0; host_wdata = cmd(8'hE0, 8'h22, 4'hF);
    @(negedge clk); host_wr = 0;
    check(mb_req && mb_write, "R3 launch", {mb_req, mb_write}, 2'b11);
    check(mb_port == 8'h03 && mb_offset == 8'h22 && mb_be == 4'hF, "R3 fields",
          {mb_port, mb_offset, mb_be}, {8'h03, 8'h22, 4'hF});
    check(mb_wdata == 32'h1234_5678, "R3 wdata", mb_wdata, 32'h1234_5678);
    check(busy, "R5 busy", busy, 1);
    wait_idle(); exp_reg[8'h22] = 32'h1234_5678;
    check(!busy, "R5 idle", busy, 0);
    hwrite(8'hD0, cmd(8'hD0, 8'h22, 4'hF)); wait_idle();
    hread(8'hD4, rd); check(rd == 32'h1234_5678, "R4 readback", rd, 32'h1234_5678);

    hwrite(8'hD4, 32'hAABB_CCDD);
    hwrite(8'hD0, cmd(8'hE0, 8'h22, 4'b0101)); wait_idle();
    exp_reg[8'h22] = merge(exp_reg[8'h22], 32'hAABB_CCDD, 4'b0101);
    hwrite(8'hD0, cmd(8'hD0, 8'h22, 4'hF)); wait_idle();
    hread(8'hD4, rd); check(rd == exp_reg[8'h22], "R8 lanes", rd, exp_reg[8'h22]);

    max_lat = 0;
    c0 = cmd(8'hD0, 8'h05, 4'hF);
    hwrite(8'hD0, c0);
    host_wr = 1; host_addr = 8'hD4; host_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    host_wdata = cmd(8'hE0, 8'h07, 4'hF); host_addr = 8'hD0;
    @(negedge clk); host_wr = 0;
    wait_idle();
    hread(8'hD4, rd); check(rd == exp_reg[5], "R6 data kept", rd, exp_reg[5]);
    hread(8'hD0, rd); check(rd == c0, "R6 ctrl kept", rd, c0);
    check(!mb_req, "R6 no relaunch", mb_req, 0);
    max_lat = 3;

    hwrite(8'hD0, 32'h5503_0AF0);
    check(err && !mb_req, "R7 bad op", {err, mb_req}, 2'b10);
    hread(8'hD0, rd); check(rd == 32'h5503_0AF0, "R9 ctrl readback", rd, 32'h5503_0AF0);
    hread(8'h40, rd); check(rd == 0, "R9 unmapped", rd, 0);
    hwrite(8'hD0, cmd(8'hD0, 8'h09, 4'hF)); wait_idle();
    hread(8'hD4, rd); check(rd == exp_reg[9], "R7 still works", rd, exp_reg[9]);
    check(err, "R7 sticky", err, 1);

    for (int it = 0; it < 300; it++) begin
      logic [7:0] o = 8'($urandom);
      logic [3:0] b = 4'($urandom);
      logic [31:0] d = $urandom;
      if ($urandom % 2) begin
        hwrite(8'hD4, d);
        hwrite(8'hD0, cmd(8'hE0, o, b)); wait_idle();
        exp_reg[o] = merge(exp_reg[o], d, b);
      end else begin
        hwrite(8'hD0, cmd(8'hD0, o, 4'hF)); wait_idle();
        hread(8'hD4, rd); check(rd == exp_reg[o], "R4/R8 random", rd, exp_reg[o]);
      end
    end
    finish_up();
  end
endmodule